// File: doc/BRIEF.md
# Clock Output Stop/Start Sequencer

This block sits in the internal reference clock domain of a clock generator. It decides, cycle by cycle, whether each of its differential outputs runs or rests. Each output is modelled as a pair of gated logic levels: a true level and a complement level. A running output alternates true-high and complement-high on successive reference cycles. A stopped output holds both levels low. One pin carries power-good during bring-up. On the first synchronized high of that pin, the block captures the two frequency/spread strap inputs once and reports them as a 3-bit code. From then on the same pin is read as an active-low power-down.

Each output runs only under four conditions. The power-good/power-down pin must be high after the strap capture. The PLL-lock flag must be set. The output's register enable bit must be set. Finally, either its enable pin must be high or the output must be marked as not stoppable. Both the pin and the enable inputs pass through a two-stage synchronizer. Every start and every stop is applied only on an edge where the true level is high. As a result, an output always finishes a full true pulse before it rests. It also restarts with a full complement pulse, and all outputs that restart together do so on the same edge.

Top module: `clkout_seq`

## Requirements
- R1: While reset is low, every true and complement output is 0, the strap-valid flag is 0 and the strap code is 3'b000.
- R2: The strap code is captured on the first edge at which the synchronized power-good pin is high, and the strap-valid flag is set on that same edge. The slow strap input uses 2'b00 = low, 2'b01 = mid and 2'b10 = high. The code is: low/high slow strap gives {1'b0, slow==high, fast}, so 000 = 100 MHz without spread, 001 = -0.5 %, 010 = ±0.25 % and 011 = -0.75 %. Mid gives 3'b100 (125 MHz) when the fast strap is 0 and 3'b101 (200 MHz) when it is 1.
- R3: Once the strap-valid flag is set, later changes of either strap input or of the power-good pin leave the code unchanged until reset.
- R4: After capture, a low on the power-good pin acts as power-down. Once the pin has been low for four edges, all outputs are Low/Low. When the pin returns high, the outputs run again.
- R5: When the enable pin of a stoppable output drops, that output stops Low/Low. Its complement never falls without its true level rising in the same cycle. The pin of an output that is not stoppable has no effect.
- R6: When the enable pins return high, the stopped outputs restart 2 to 6 reference cycles after the pin change, and outputs restarted together start on the same cycle.
- R7: A cleared register enable bit keeps its output Low/Low whatever its enable pin says.
- R8: With PLL-lock low for two edges, all outputs are Low/Low. When lock returns, all enabled outputs start together.
- R9: The internal phase is 0 at reset and flips on every edge. A running output has true = phase and complement = inverse phase, so each true pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Internal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_pdn | input | 1 | Power-good, then active-low power-down (asynchronous) |
| strap_fast | input | 1 | Two-level strap bit |
| strap_slow | input | 2 | Three-level strap: 00 low, 01 mid, 10 high |
| oe_pin | input | NOUT | Per-output enable pins (asynchronous) |
| oe_reg | input | NOUT | Per-output register enable bits |
| stop_ok | input | NOUT | 1 marks an output as stoppable by its pin |
| pll_lock | input | 1 | PLL locked flag |
| strap_vld | output | 1 | Strap code captured |
| strap_code | output | 3 | Captured frequency/spread code |
| true_o | output | NOUT | True level of each output |
| comp_o | output | NOUT | Complement level of each output |

## Verification
The hardest condition to reach is the capture window. It has to be shown that the straps are taken exactly once, even after the power-good pin has dropped and risen again, and that a second capture is possible only after reset. The stimulus moves the straps while the pin is still low and checks that nothing is captured. It then raises the pin and, after capture, changes the straps and pulses the pin through a full power-down. Finally it resets and captures a different code. The restart latency is measured by counting cycles from the pin change, so the check does not depend on the phase at that moment.

// File: rtl/clkout_seq.sv
module clkout_seq #(
  parameter int NOUT = 4,
  parameter int SYNC = 2
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic            pwrgd_pdn,
  input  logic            strap_fast,
  input  logic [1:0]      strap_slow,
  input  logic [NOUT-1:0] oe_pin,
  input  logic [NOUT-1:0] oe_reg,
  input  logic [NOUT-1:0] stop_ok,
  input  logic            pll_lock,
  output logic            strap_vld,
  output logic [2:0]      strap_code,
  output logic [NOUT-1:0] true_o,
  output logic [NOUT-1:0] comp_o
);
  logic [SYNC-1:0]            pg_sh;
  logic [SYNC-1:0][NOUT-1:0]  oe_sh;
  logic [NOUT-1:0]            run, want;
  logic                       phase, pg_s, gate;
  logic [2:0]                 code_in;

  assign pg_s    = pg_sh[SYNC-1];
  assign code_in = (strap_slow == 2'b01) ? {2'b10, strap_fast}
                                         : {1'b0, strap_slow[1], strap_fast};
  assign gate    = strap_vld & pg_s & pll_lock;
  assign want    = {NOUT{gate}} & oe_reg & (oe_sh[SYNC-1] | ~stop_ok);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pg_sh      <= '0;
      oe_sh      <= '0;
      strap_vld  <= 1'b0;
      strap_code <= 3'b000;
      phase      <= 1'b0;
      run        <= '0;
    end else begin
      pg_sh <= {pg_sh[SYNC-2:0], pwrgd_pdn};
      oe_sh <= {oe_sh[SYNC-2:0], oe_pin};
      if (!strap_vld && pg_s) begin
        strap_vld  <= 1'b1;
        strap_code <= code_in;
      end
      phase <= ~phase;
      if (phase) run <= want;
    end
  end

  assign true_o = run & {NOUT{phase}};
  assign comp_o = run & ~{NOUT{phase}};
endmodule

// File: rtl/clkout_seq_chk.sv
module clkout_seq_chk #(
  parameter int NOUT = 4
) (
  input logic            clk_ref,
  input logic            rst_n,
  input logic            pwrgd_pdn,
  input logic            pll_lock,
  input logic [NOUT-1:0] oe_reg,
  input logic            strap_vld,
  input logic [2:0]      strap_code,
  input logic [NOUT-1:0] true_o,
  input logic [NOUT-1:0] comp_o
);
  logic [2:0] lowcnt;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)         lowcnt <= '0;
    else if (pwrgd_pdn) lowcnt <= '0;
    else if (lowcnt != 3'd7) lowcnt <= lowcnt + 3'd1;
  end

  // R3
  strap_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    strap_vld |=> (strap_vld && $stable(strap_code)));
  // R4
  pdn_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (lowcnt >= 3'd4) |-> ((true_o | comp_o) == '0));
  // R8
  lock_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!pll_lock && $past(!pll_lock)) |=> ((true_o | comp_o) == '0));

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    // R7
    reg_off_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!oe_reg[i] && $past(!oe_reg[i])) |=> (!true_o[i] && !comp_o[i]));
    // R9
    pulse_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(true_o[i]) |=> !true_o[i]);
    // R5
    stop_lowlow_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $fell(comp_o[i]) |-> true_o[i]);
  end
endmodule

bind clkout_seq clkout_seq_chk #(.NOUT(NOUT)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .pwrgd_pdn(pwrgd_pdn), .pll_lock(pll_lock),
  .oe_reg(oe_reg), .strap_vld(strap_vld), .strap_code(strap_code),
  .true_o(true_o), .comp_o(comp_o));

// File: tb/clkout_seq_test.sv
module clkout_seq_test;
  localparam int PER  = 10;
  localparam int NOUT = 4;

  logic clk_ref = 1'b0, rst_n = 1'b0, pwrgd_pdn = 1'b0, strap_fast = 1'b0, pll_lock = 1'b0;
  logic [1:0] strap_slow = 2'b00;
  logic [NOUT-1:0] oe_pin = '1, oe_reg = '1, stop_ok = 4'b0011;
  logic strap_vld;
  logic [2:0] strap_code;
  logic [NOUT-1:0] true_o, comp_o;

  always #(PER/2) clk_ref = ~clk_ref;

  clkout_seq #(.NOUT(NOUT)) uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .pwrgd_pdn(pwrgd_pdn), .strap_fast(strap_fast),
    .strap_slow(strap_slow), .oe_pin(oe_pin), .oe_reg(oe_reg), .stop_ok(stop_ok),
    .pll_lock(pll_lock), .strap_vld(strap_vld), .strap_code(strap_code),
    .true_o(true_o), .comp_o(comp_o));

  logic ph;
  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) ph <= 1'b0; else ph <= ~ph;

  typedef struct { string req; logic [11:0] exp; logic [11:0] mask; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic score(string req, bit ok, int got, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic push(string req, logic [11:0] exp, logic [11:0] mask);
    item_t it;
    it.req = req; it.exp = exp; it.mask = mask;
    q.push_back(it);
  endtask

  task automatic check_run(string req, logic [NOUT-1:0] m);
    push(req, {4'h0, m & {NOUT{ph}}, m & ~{NOUT{ph}}}, 12'h0FF);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  initial begin
    forever begin
      item_t it;
      logic [11:0] obs;
      wait (q.size() > 0);
      it  = q.pop_front();
      obs = {strap_vld, strap_code, true_o, comp_o};
      score(it.req, (obs & it.mask) == (it.exp & it.mask),
            int'(obs & it.mask), int'(it.exp & it.mask));
    end
  end

  initial begin
    #(PER * 50000);
    if (!done) begin
      score("watchdog", 1'b0, 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    strap_slow = 2'b01; strap_fast = 1'b1;
    tick(2);
    push("R1 reset", 12'h000, 12'hFFF);
    rst_n = 1'b1;
    strap_slow = 2'b10; tick(1); strap_slow = 2'b01;
    tick(3);
    push("R2 no capture while pin low", 12'h000, 12'h800);
    pwrgd_pdn = 1'b1;
    tick(4);
    push("R2 mid/1 code", {1'b1, 3'b101, 8'h00}, 12'hF00);
    strap_slow = 2'b00; strap_fast = 1'b0;
    tick(3);
    push("R3 straps moved", {1'b1, 3'b101, 8'h00}, 12'hF00);
    push("R8 held without lock", 12'h000, 12'h0FF);
    pll_lock = 1'b1;
    tick(3);
    check_run("R8 all start", 4'b1111); tick(1);
    check_run("R9 alternation", 4'b1111); tick(1);
    check_run("R9 alternation", 4'b1111);
    oe_pin = 4'b1010;
    tick(5);
    check_run("R5 stop stoppable only", 4'b1110); tick(1);
    check_run("R5 stop stoppable only", 4'b1110);
    oe_pin = 4'b1000;
    tick(5);
    check_run("R6 both stopped", 4'b1100);
    oe_pin = 4'b1111;
    begin
      int n = 0;
      do begin tick(1); n++; end while (((true_o | comp_o) & 4'b0011) == 0 && n < 12);
      score("R6 latency", n >= 2 && n <= 6, n, 4);
      score("R6 simultaneous", ((true_o | comp_o) & 4'b0011) == 4'b0011,
            int'((true_o | comp_o) & 4'b0011), 3);
    end
    tick(2);
    check_run("R6 running", 4'b1111);
    oe_reg = 4'b0111;
    tick(3);
    check_run("R7 reg clear", 4'b0111); tick(1);
    check_run("R7 reg clear", 4'b0111);
    oe_reg = 4'b1111;
    tick(3);
    check_run("R7 reg set", 4'b1111);
    pll_lock = 1'b0;
    tick(3);
    push("R8 lock lost", 12'h000, 12'h0FF);
    pll_lock = 1'b1;
    tick(3);
    check_run("R8 lock back", 4'b1111);
    pwrgd_pdn = 1'b0;
    tick(4);
    push("R4 power-down", {1'b1, 3'b101, 8'h00}, 12'hFFF); tick(1);
    push("R4 power-down", {1'b1, 3'b101, 8'h00}, 12'hFFF);
    pwrgd_pdn = 1'b1;
    tick(6);
    check_run("R4 exit", 4'b1111);
    push("R3 after power-down", {1'b1, 3'b101, 8'h00}, 12'hF00);
    rst_n = 1'b0; pwrgd_pdn = 1'b0; strap_slow = 2'b10; strap_fast = 1'b0;
    tick(2);
    push("R1 second reset", 12'h000, 12'hFFF);
    rst_n = 1'b1; pwrgd_pdn = 1'b1;
    tick(4);
    push("R2 high/0 code", {1'b1, 3'b010, 8'h00}, 12'hF00);
    tick(1);
    wait (q.size() == 0);
    tick(1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule